// File: doc/BRIEF.md
# Bit-Interleaved Double-Rate Converter Sample Capture

This block sits between a system clock domain and an analog-to-digital converter. The converter drives 8 data lines at twice its own sample rate. In one system-clock cycle the lines carry the even-indexed bits of a 16-bit sample, and in the next cycle they carry the odd-indexed bits. The whole block runs on one system clock. It generates the converter's clock by dividing that system clock by two with a toggle register, and it sends the clock out through a register.

Incoming bus words and the converter's data strobe pass through one input register stage. Each bus half is then loaded into its own capture register, which is only written in its own phase. That register spreads the 8 bits over alternate positions of a 16-bit word and holds zero in the other positions. The finished sample is the bitwise OR of the two capture registers, so no selection multiplexer is needed. The sample is presented with a one-cycle valid strobe. A parameter selects whether the phase comes from the local divided clock (the default) or from the pipelined converter strobe.

Top module: `adcc_ddr_capture`

## Requirements
- R1: `conv_clk` is low after the first active clock edge following reset release and goes high after the second. From then on it inverts on every edge, so it runs at half the system clock rate.
- R2: In the merged sample, bit 2k equals line k of the even half-word and bit 2k+1 equals line k of the odd half-word, for k = 0..7.
- R3: The even half-word is the value on `adc_bus` during a cycle in which `conv_clk` reads low. The odd half-word is the value during the next cycle, in which `conv_clk` reads high. Each capture register changes only in its own phase, so a sample never combines halves from two different pairs.
- R4: `sample_valid` and the matching `sample` appear after the second clock edge that follows the edge at which the odd half-word is sampled.
- R5: `sample_valid` lasts exactly one cycle, comes at most every other cycle, and is only asserted while `conv_clk` reads low.
- R6: `sample` holds its value in every cycle in which `sample_valid` is low.
- R7: A synchronous active-low reset (`rst_n` low at a clock edge) forces `conv_clk`, `sample_valid` and `sample` to zero on that edge.
- R8: After reset release, no `sample_valid` appears before the fifth clock edge. The first sample is built from the words on the bus during the second and third cycles after release. An odd half seen before any even half has been captured produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_bus | input | 8 | Interleaved converter data lines |
| adc_strobe | input | 1 | Data strobe returned by the converter |
| conv_clk | output | 1 | Registered half-rate converter clock |
| sample | output | 16 | Merged sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench plays the converter. It looks at `conv_clk` every cycle and drives either the even or the odd half of the next pattern. The patterns are walking ones, all-zero, all-one, alternating masks and a strided sweep over the 16-bit space. Any swap of the line-to-bit mapping, or of the even and odd phases, then shows up as scrambled bits in the merged word. The bench predicts the exact cycle of every strobe. An extra or missing pipeline register therefore moves the strobe off its slot, and a missing arming guard produces a spurious sample right after reset. A reset in the middle of the stream checks that all outputs clear, and that capture then restarts with the correct first pair instead of a leftover half from before the reset.

// File: rtl/adcc_pkg.sv
// Package shared by the interleaved capture block.
// Holds the phase type and the default bus geometry.
package adcc_pkg;

    // Which half of a sample a capture register holds.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // Default number of converter data lines.
    localparam int unsigned LANES_DEF = 8;

endpackage

// File: rtl/adcc_clkdiv.sv
// Divide-by-two converter clock generator.
// A toggle register runs at half the system rate. A second register
// drives the pin, so the pin has no logic in front of it.
// Assumes: single system clock, synchronous active-low reset.
module adcc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic clk_out,
    output logic phase_hi
);

    logic toggle_q;
    logic out_q;

    // Toggle on every system edge.
    always_ff @(posedge clk) begin
        if (!rst_n) toggle_q <= 1'b0;
        else        toggle_q <= ~toggle_q;
    end

    // Output pipeline stage for the converter clock pin.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= toggle_q;
    end

    assign clk_out  = out_q;
    assign phase_hi = out_q;

endmodule

// File: rtl/adcc_inpipe.sv
// Input register stage for the converter data lines and strobe.
// Assumes the inputs are stable around the system clock edge.
module adcc_inpipe #(
    parameter int unsigned LANES = adcc_pkg::LANES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] bus_in,
    input  logic             strobe_in,
    output logic [LANES-1:0] bus_q,
    output logic             strobe_q
);

    // Register the data lines.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_in;
    end

    // Register the returned converter strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_in;
    end

endmodule

// File: rtl/adcc_phase_capture.sv
// One phase capture register.
// Loads the pipelined bus only when its own phase is active. Line k goes
// to bit 2k+PARITY of a full-width word; the other bits stay zero, so two
// of these registers can be merged with a plain OR.
module adcc_phase_capture #(
    parameter int unsigned     LANES  = adcc_pkg::LANES_DEF,
    parameter adcc_pkg::phase_e PARITY = adcc_pkg::PH_EVEN,
    localparam int unsigned    WORD_W = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANES-1:0]  bus_q,
    output logic [WORD_W-1:0] word_q
);

    localparam int unsigned OFS = (PARITY == adcc_pkg::PH_ODD) ? 1 : 0;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Captured bit for line k in this phase.
        always_ff @(posedge clk) begin
            if (!rst_n)    word_q[2*k+OFS] <= 1'b0;
            else if (load) word_q[2*k+OFS] <= bus_q[k];
        end
        // Position belonging to the other phase is tied to zero.
        assign word_q[2*k+1-OFS] = 1'b0;
    end

endmodule

// File: rtl/adcc_merge.sv
// Merge and strobe stage.
// Raises a one-cycle strobe and registers the OR of both phase words
// in the cycle after an odd capture that follows an even capture.
module adcc_merge #(
    parameter int unsigned LANES  = adcc_pkg::LANES_DEF,
    localparam int unsigned WORD_W = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              even_load,
    input  logic              odd_load,
    input  logic [WORD_W-1:0] even_word,
    input  logic [WORD_W-1:0] odd_word,
    output logic [WORD_W-1:0] sample_q,
    output logic              valid_q
);

    logic armed_q;
    logic pair_done_q;

    // Remember that an even half exists, so an orphan odd half is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (even_load) armed_q <= 1'b1;
    end

    // Flag a completed pair one cycle after its odd half is captured.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_done_q <= 1'b0;
        else        pair_done_q <= odd_load & armed_q;
    end

    // Output register: merged word and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= pair_done_q;
            if (pair_done_q) sample_q <= even_word | odd_word;
        end
    end

endmodule

// File: rtl/adcc_ddr_capture.sv
// Top of the interleaved converter capture block.
// Generates the half-rate converter clock and registers the incoming lines.
// Captures the even and odd halves in separate scattered registers and
// emits each merged sample with a one-cycle strobe.
// Assumes: one system clock; converter data already aligned to it.
module adcc_ddr_capture #(
    parameter int unsigned LANES             = adcc_pkg::LANES_DEF,
    parameter bit          PHASE_FROM_STROBE = 1'b0,
    localparam int unsigned WORD_W           = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  adc_bus,
    input  logic              adc_strobe,
    output logic              conv_clk,
    output logic [WORD_W-1:0] sample,
    output logic              sample_valid
);

    logic             div_phase;
    logic [LANES-1:0] bus_q;
    logic             strobe_q;
    logic             phase_hi;
    logic             even_load;
    logic             odd_load;
    logic [WORD_W-1:0] even_word;
    logic [WORD_W-1:0] odd_word;

    adcc_clkdiv u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_out  (conv_clk),
        .phase_hi (div_phase)
    );

    adcc_inpipe #(.LANES(LANES)) u_inpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (adc_bus),
        .strobe_in (adc_strobe),
        .bus_q     (bus_q),
        .strobe_q  (strobe_q)
    );

    // Phase source: local divider by default, or the returned strobe.
    if (PHASE_FROM_STROBE) begin : g_ph_strobe
        logic unused_div;
        assign phase_hi   = strobe_q;
        assign unused_div = div_phase;
    end else begin : g_ph_local
        logic unused_strobe;
        assign phase_hi      = div_phase;
        assign unused_strobe = strobe_q;
    end

    // Each capture register loads only in its own phase.
    assign even_load = phase_hi;
    assign odd_load  = ~phase_hi;

    adcc_phase_capture #(.LANES(LANES), .PARITY(adcc_pkg::PH_EVEN)) u_cap_even (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (even_load),
        .bus_q  (bus_q),
        .word_q (even_word)
    );

    adcc_phase_capture #(.LANES(LANES), .PARITY(adcc_pkg::PH_ODD)) u_cap_odd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (odd_load),
        .bus_q  (bus_q),
        .word_q (odd_word)
    );

    adcc_merge #(.LANES(LANES)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .even_load (even_load),
        .odd_load  (odd_load),
        .even_word (even_word),
        .odd_word  (odd_word),
        .sample_q  (sample),
        .valid_q   (sample_valid)
    );

endmodule

// File: rtl/adcc_ddr_capture_chk.sv
// Port-level checker for adcc_ddr_capture, attached with bind below.
module adcc_ddr_capture_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_clk,
    input logic [WORD_W-1:0] sample,
    input logic              sample_valid
);

    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_CLK_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_clk |=> !conv_clk); // R1

    AST_CLK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !conv_clk) |=> conv_clk); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid); // R5

    AST_VALID_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !conv_clk); // R5

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!conv_clk && !sample_valid && sample == '0)); // R7

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !sample_valid); // R8

endmodule

bind adcc_ddr_capture adcc_ddr_capture_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_clk     (conv_clk),
    .sample       (sample),
    .sample_valid (sample_valid)
);

// File: tb/adcc_ddr_capture_test.sv
module adcc_ddr_capture_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  LANES      = 8;
    localparam int  WW         = 2 * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] adc_bus = '0;
    logic             adc_strobe = 1'b0;
    logic             conv_clk;
    logic [WW-1:0]    sample;
    logic             sample_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          ecnt;
    int          due_q [4];
    logic [WW-1:0] val_q [4];
    int          qh, qn;
    logic [WW-1:0] last_s;
    logic [WW-1:0] cur;
    int          pidx;

    adcc_ddr_capture uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_bus      (adc_bus),
        .adc_strobe   (adc_strobe),
        .conv_clk     (conv_clk),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge counter since reset release (bench timebase).
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    function automatic logic [LANES-1:0] half_of(input logic [WW-1:0] s, input int par);
        logic [LANES-1:0] w;
        for (int k = 0; k < LANES; k++) w[k] = s[2*k+par];
        return w;
    endfunction

    // Pattern sequence: walking ones, corner masks, then a strided sweep.
    function automatic logic [WW-1:0] pat(input int n);
        if (n < WW) return WW'(1) << n;
        case (n - WW)
            0: return '0;
            1: return '1;
            2: return 16'hAAAA;
            3: return 16'h5555;
            default: return WW'((n * 37 + 11) % 65536);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at edge %0d", req, what, act, exp, ecnt);
        end
    endtask

    task automatic bench_clear();
        qh = 0; qn = 0; last_s = '0; pidx = 0; cur = '0;
    endtask

    // Converter model: drive the half selected by conv_clk.
    task automatic drive();
        adc_strobe = conv_clk;
        if (!conv_clk) begin
            cur     = pat(pidx);
            pidx++;
            adc_bus = half_of(cur, 0);
        end else begin
            adc_bus = half_of(cur, 1);
            due_q[(qh + qn) % 4] = ecnt + 3;
            val_q[(qh + qn) % 4] = cur;
            qn++;
        end
    endtask

    // Compare outputs after the latest edge with the predicted schedule.
    task automatic check_outputs();
        bit exp_clk;
        bit exp_v;
        exp_clk = (ecnt >= 2) && (ecnt % 2 == 0);
        chk(conv_clk == exp_clk, "R1", "conv_clk", WW'(conv_clk), WW'(exp_clk));
        exp_v = (qn > 0) && (due_q[qh] == ecnt);
        if (ecnt < 5)
            chk(sample_valid == 1'b0, "R8", "early valid", WW'(sample_valid), '0);
        else
            chk(sample_valid == exp_v, "R4", "valid slot", WW'(sample_valid), WW'(exp_v));
        if (exp_v) begin
            chk(sample == val_q[qh], "R2", "merged sample (R3 pairing)", sample, val_q[qh]);
            last_s = val_q[qh];
            qh = (qh + 1) % 4;
            qn--;
        end else begin
            chk(sample == last_s, "R6", "sample hold", sample, last_s);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_outputs();
            drive();
        end
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        adc_bus = '0;
        for (int i = 0; i < n; i++) @(negedge clk);
        chk(conv_clk == 1'b0, "R7", "reset conv_clk", WW'(conv_clk), '0);
        chk(sample_valid == 1'b0, "R7", "reset valid", WW'(sample_valid), '0);
        chk(sample == '0, "R7", "reset sample", sample, '0);
        bench_clear();
        rst_n = 1'b1;
        drive();
    endtask

    initial begin
        bench_clear();
        @(negedge clk);
        do_reset(4);
        run(4000);
        // Reset in the middle of a pair, then restart capture.
        do_reset(3);
        run(600);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule